// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds the most recently used virtual-page to physical-frame mappings for a processor's load/store path. A lookup presents a 43-bit virtual address and an access type (read or write). All 32 stored entries are compared against the 30-bit virtual page number at once. On a match with permission, the block returns a 34-bit physical address in the same cycle, along with the entry's dirty and referenced status. On a match without permission it raises a protection fault. When nothing matches it raises a miss, so that an external page walker can answer with a refill.

Refills go into the lowest-numbered empty entry. Once the buffer is full, a pseudo-random victim is used, and that victim is never the entry touched most recently. A page-table-entry write strobe invalidates the whole buffer in one cycle. Write hits mark the entry dirty, and all successful hits mark it referenced. These status bits are the input to later write-back and replacement decisions elsewhere in the memory system.

Top module: `tlb_fa_top`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss. While lookupValid is low, hit, miss, protFault, physAddr, hitDirty and hitRef are all 0.
- R2: The virtual address splits as page number = lookupVa[42:13] and offset = lookupVa[12:0]. A permitted lookup that matches a valid entry asserts hit combinationally in the same cycle, with physAddr = {frame[20:0], offset[12:0]}. physAddr is 0 whenever hit is low.
- R3: A valid lookup that matches no valid entry asserts miss. At most one of hit, miss and protFault is high in any cycle.
- R4: Each entry carries a 2-bit read permission and a 2-bit write permission. A value of 0 in the field for the requested access (lookupWrite=1 means write) denies the access: protFault is asserted instead of hit, and the entry's status bits are left unchanged.
- R5: A hit sets the entry's referenced bit at the next clock edge. hitRef shows the stored bit as it was before this lookup. A refill clears the bit.
- R6: A write hit sets the entry's dirty bit at the next clock edge. hitDirty shows the stored bit. A refill clears it.
- R7: While any entry is invalid, a refill writes the lowest-indexed invalid entry.
- R8: When all entries are valid, the refill victim is the current value of a 5-bit LFSR. The LFSR resets to 1 and advances on every clock as next = {q[3:0], q[4]^q[2]}.
- R9: The most recently used entry is the one last written by a refill or, failing that, the one last hit. It starts at 0 after reset. If the LFSR value equals it, the victim becomes (LFSR+1) mod 32.
- R10: pteWrite clears every valid bit at the next edge. A refill in the same cycle is discarded.
- R11: A lookup in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupWrite | input | 1 | 1 = write access, 0 = read access |
| lookupVa | input | 43 | Virtual address (page number and offset) |
| hit | output | 1 | Permitted match |
| miss | output | 1 | No valid entry matches |
| protFault | output | 1 | Match but access type not permitted |
| physAddr | output | 34 | Translated address on hit, else 0 |
| hitDirty | output | 1 | Stored dirty bit of hit entry |
| hitRef | output | 1 | Stored referenced bit of hit entry |
| refillValid | input | 1 | Install a new mapping |
| refillVpn | input | 30 | Page number of new mapping |
| refillPfn | input | 21 | Frame number of new mapping |
| refillRdPerm | input | 2 | Read permission of new mapping |
| refillWrPerm | input | 2 | Write permission of new mapping |
| pteWrite | input | 1 | Page table entry written: invalidate all |

## Verification
The hardest case to reach is a full buffer whose LFSR value equals the index of the most recently used entry at the moment a refill arrives. Only then does the substitute victim take effect. The bench reaches it by filling every entry and hitting a chosen nonzero index. It then idles while tracking the LFSR in its own model, and issues the refill in the exact cycle the two values coincide. The same sequence is repeated with index 31, so that the substitute wraps around to entry 0.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;
  localparam int ENTRIES = 32;
  localparam int VPN_W   = 30;
  localparam int PFN_W   = 21;
  localparam int OFF_W   = 13;
  localparam int PERM_W  = 2;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int VA_W    = VPN_W + OFF_W;
  localparam int PA_W    = PFN_W + OFF_W;
  localparam logic [IDX_W-1:0] LFSR_SEED = 1;
  localparam logic [IDX_W-1:0] LFSR_TAPS = 5'b10100;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] rdPerm;
    logic [PERM_W-1:0] wrPerm;
    logic              dirty;
    logic              refd;
  } tlbEntry_t;

  typedef struct packed {
    logic             flush;
    logic             fill;
    logic [IDX_W-1:0] fillIdx;
    logic             touch;
    logic             markDirty;
    logic [IDX_W-1:0] touchIdx;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_fa_data.sv
module tlb_fa_data
  import tlb_fa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [PERM_W-1:0] fillRd,
  input  logic [PERM_W-1:0] fillWr,
  output logic              matchAny,
  output logic [IDX_W-1:0]  matchIdx,
  output tlbEntry_t         matchEntry,
  output logic [ENTRIES-1:0] validVec
);
  tlbEntry_t entryQ [ENTRIES];
  logic [ENTRIES-1:0] matchVec;

  // parallel compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = entryQ[g].valid && (entryQ[g].vpn == lookupVpn);
    assign validVec[g] = entryQ[g].valid;
  end

  assign matchAny = |matchVec;

  // lowest index wins
  always_comb begin
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) matchIdx = IDX_W'(i);
    end
  end

  assign matchEntry = entryQ[matchIdx];

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rstN) begin
        entryQ[i] <= '0;
      end else if (strobe.flush) begin
        entryQ[i].valid <= 1'b0;
      end else if (strobe.fill && strobe.fillIdx == IDX_W'(i)) begin
        entryQ[i].valid  <= 1'b1;
        entryQ[i].vpn    <= fillVpn;
        entryQ[i].pfn    <= fillPfn;
        entryQ[i].rdPerm <= fillRd;
        entryQ[i].wrPerm <= fillWr;
        entryQ[i].dirty  <= 1'b0;
        entryQ[i].refd   <= 1'b0;
      end else if (strobe.touch && strobe.touchIdx == IDX_W'(i)) begin
        entryQ[i].refd <= 1'b1;
        if (strobe.markDirty) entryQ[i].dirty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_fa_ctrl.sv
module tlb_fa_ctrl
  import tlb_fa_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic               matchAny,
  input  logic [IDX_W-1:0]   matchIdx,
  input  logic [PERM_W-1:0]  matchRd,
  input  logic [PERM_W-1:0]  matchWr,
  input  logic [ENTRIES-1:0] validVec,
  input  logic               refillValid,
  input  logic               pteWrite,
  output logic               hit,
  output logic               miss,
  output logic               protFault,
  output tlbStrobe_t         strobe
);
  logic [IDX_W-1:0] lfsrQ, lastUsedQ, firstFree, randIdx, victim;
  logic             anyFree, permOk;

  assign permOk    = lookupWrite ? (|matchWr) : (|matchRd);
  assign hit       = lookupValid && matchAny && permOk;
  assign protFault = lookupValid && matchAny && !permOk;
  assign miss      = lookupValid && !matchAny;

  always_comb begin
    anyFree   = 1'b0;
    firstFree = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        anyFree   = 1'b1;
        firstFree = IDX_W'(i);
      end
    end
  end

  assign randIdx = (lfsrQ == lastUsedQ) ? lfsrQ + 1'b1 : lfsrQ;
  assign victim  = anyFree ? firstFree : randIdx;

  always_comb begin
    strobe           = '0;
    strobe.flush     = pteWrite;
    strobe.fill      = refillValid && !pteWrite;
    strobe.fillIdx   = victim;
    strobe.touch     = hit && !pteWrite;
    strobe.markDirty = hit && lookupWrite;
    strobe.touchIdx  = matchIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ     <= LFSR_SEED;
      lastUsedQ <= '0;
    end else begin
      lfsrQ <= {lfsrQ[IDX_W-2:0], ^(lfsrQ & LFSR_TAPS)};
      if (strobe.fill)       lastUsedQ <= victim;
      else if (strobe.touch) lastUsedQ <= matchIdx;
    end
  end
endmodule

// File: rtl/tlb_fa_top.sv
module tlb_fa_top
  import tlb_fa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic              lookupWrite,
  input  logic [VA_W-1:0]   lookupVa,
  output logic              hit,
  output logic              miss,
  output logic              protFault,
  output logic [PA_W-1:0]   physAddr,
  output logic              hitDirty,
  output logic              hitRef,
  input  logic              refillValid,
  input  logic [VPN_W-1:0]  refillVpn,
  input  logic [PFN_W-1:0]  refillPfn,
  input  logic [PERM_W-1:0] refillRdPerm,
  input  logic [PERM_W-1:0] refillWrPerm,
  input  logic              pteWrite
);
  tlbStrobe_t         strobe;
  tlbEntry_t          matchEntry;
  logic               matchAny;
  logic [IDX_W-1:0]   matchIdx;
  logic [ENTRIES-1:0] validVec;

  tlb_fa_data data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookupVpn(lookupVa[VA_W-1:OFF_W]),
    .fillVpn(refillVpn), .fillPfn(refillPfn),
    .fillRd(refillRdPerm), .fillWr(refillWrPerm),
    .matchAny(matchAny), .matchIdx(matchIdx),
    .matchEntry(matchEntry), .validVec(validVec)
  );

  tlb_fa_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .matchAny(matchAny), .matchIdx(matchIdx),
    .matchRd(matchEntry.rdPerm), .matchWr(matchEntry.wrPerm),
    .validVec(validVec), .refillValid(refillValid), .pteWrite(pteWrite),
    .hit(hit), .miss(miss), .protFault(protFault), .strobe(strobe)
  );

  assign physAddr = hit ? {matchEntry.pfn, lookupVa[OFF_W-1:0]} : '0;
  assign hitDirty = hit && matchEntry.dirty;
  assign hitRef   = hit && matchEntry.refd;
endmodule

// File: rtl/tlb_fa_checker.sv
module tlb_fa_checker
  import tlb_fa_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            lookupValid,
  input logic            lookupWrite,
  input logic [VA_W-1:0] lookupVa,
  input logic            hit,
  input logic            miss,
  input logic            protFault,
  input logic [PA_W-1:0] physAddr,
  input logic            hitDirty,
  input logic            hitRef,
  input logic            refillValid,
  input logic            pteWrite
);
  // R3
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, miss, protFault}));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(hit || miss || protFault || hitDirty || hitRef));
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> physAddr[OFF_W-1:0] == lookupVa[OFF_W-1:0]);
  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    pteWrite |=> (lookupValid |-> (!hit && !protFault)));
  // R6
  dirty_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && lookupWrite && !pteWrite && !refillValid)
      |=> ((hit && $stable(lookupVa)) |-> hitDirty));
  // R5
  ref_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && !pteWrite && !refillValid)
      |=> ((hit && $stable(lookupVa)) |-> hitRef));
endmodule

bind tlb_fa_top tlb_fa_checker chk_i (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
  .lookupVa(lookupVa), .hit(hit), .miss(miss), .protFault(protFault),
  .physAddr(physAddr), .hitDirty(hitDirty), .hitRef(hitRef),
  .refillValid(refillValid), .pteWrite(pteWrite)
);

// File: tb/tlb_fa_top_tb_top.sv
module tlb_fa_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 0, lookupWrite = 0, refillValid = 0, pteWrite = 0;
  logic [42:0] lookupVa = '0;
  logic [29:0] refillVpn = '0;
  logic [20:0] refillPfn = '0;
  logic [1:0]  refillRdPerm = '0, refillWrPerm = '0;
  logic hit, miss, protFault, hitDirty, hitRef;
  logic [33:0] physAddr;

  always #2 clk = ~clk;

  tlb_fa_top dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupVa(lookupVa), .hit(hit), .miss(miss), .protFault(protFault),
    .physAddr(physAddr), .hitDirty(hitDirty), .hitRef(hitRef),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillPfn(refillPfn),
    .refillRdPerm(refillRdPerm), .refillWrPerm(refillWrPerm), .pteWrite(pteWrite)
  );

  // behavioural reference state
  bit mValid[32]; bit mDirty[32]; bit mRef[32];
  int mVpn[32]; int mPfn[32]; int mRd[32]; int mWr[32];
  int mLfsr = 1;
  int mLast = 0;
  int nChecks = 0, nFails = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // compare outputs this cycle, then advance the model at the edge
  task automatic step(input string req);
    int mi, victim, vpnIn, offIn, free;
    bit eHit, eMiss, eFault, ok;
    longint ePa;
    #1;
    vpnIn = int'(lookupVa[42:13]);
    offIn = int'(lookupVa[12:0]);
    mi = -1;
    for (int i = 0; i < 32; i++)
      if (mi < 0 && mValid[i] && mVpn[i] == vpnIn) mi = i;
    ok = (mi >= 0) && (lookupWrite ? (mWr[mi] != 0) : (mRd[mi] != 0));
    eHit = lookupValid && ok;
    eFault = lookupValid && (mi >= 0) && !ok;
    eMiss = lookupValid && (mi < 0);
    ePa = eHit ? ((longint'(mPfn[mi]) << 13) | offIn) : 0;
    check(req, "hit", hit, eHit);
    check(req, "miss", miss, eMiss);
    check(req, "protFault", protFault, eFault);
    check(req, "physAddr", physAddr, ePa);
    check(req, "hitDirty", hitDirty, eHit ? mDirty[mi] : 0);
    check(req, "hitRef", hitRef, eHit ? mRef[mi] : 0);
    @(posedge clk);
    if (pteWrite) begin
      for (int i = 0; i < 32; i++) mValid[i] = 0;
    end else begin
      if (eHit) begin
        mRef[mi] = 1;
        if (lookupWrite) mDirty[mi] = 1;
        mLast = mi;
      end
      if (refillValid) begin
        free = -1;
        for (int i = 0; i < 32; i++) if (free < 0 && !mValid[i]) free = i;
        if (free >= 0) victim = free;
        else victim = (mLfsr == mLast) ? (mLfsr + 1) % 32 : mLfsr;
        mValid[victim] = 1; mVpn[victim] = int'(refillVpn); mPfn[victim] = int'(refillPfn);
        mRd[victim] = int'(refillRdPerm); mWr[victim] = int'(refillWrPerm);
        mDirty[victim] = 0; mRef[victim] = 0;
        mLast = victim;
      end
    end
    mLfsr = ((mLfsr << 1) & 31) | (((mLfsr >> 4) ^ (mLfsr >> 2)) & 1);
    @(negedge clk);
  endtask

  task automatic clearIn();
    lookupValid = 0; lookupWrite = 0; refillValid = 0; pteWrite = 0;
  endtask

  task automatic lookup(input int vpn, input int off, input bit wr, input string req);
    lookupValid = 1; lookupWrite = wr; lookupVa = {30'(vpn), 13'(off)};
    step(req); clearIn();
  endtask

  task automatic refill(input int vpn, input int pfn, input int rd, input int wr, input string req);
    refillValid = 1; refillVpn = 30'(vpn); refillPfn = 21'(pfn);
    refillRdPerm = 2'(rd); refillWrPerm = 2'(wr);
    step(req); clearIn();
  endtask

  // drive to the cycle where the LFSR equals the last-used index, then refill
  task automatic collideRefill(input int k, input int vpn, input string req);
    int guard = 0;
    lookup(mVpn[k], 16, 0, req);
    while (mLfsr != mLast && guard < 40) begin
      step(req); guard++;
    end
    check(req, "collision reached", guard < 40, 1);
    refill(vpn, 21'h1ABCD, 1, 1, req);
    for (int i = 0; i < 32; i++) lookup(mVpn[i], i * 7, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: empty after reset, quiet when idle
    step("R1");
    lookup(5, 3, 0, "R1");
    lookup(0, 0, 1, "R1");
    // R7: fill lowest free entries
    for (int i = 0; i < 4; i++) refill(10 + i, 100 + i, 1, 1, "R7");
    // R2: translate with several offsets
    lookup(10, 13'h1FFF, 0, "R2");
    lookup(13, 0, 0, "R2");
    lookup(11, 13'h0A5A, 1, "R2");
    // R3: absent page
    lookup(99, 1, 0, "R3");
    // R4: permission fields
    refill(20, 300, 0, 2, "R4");
    refill(21, 301, 3, 0, "R4");
    lookup(20, 4, 0, "R4");
    lookup(20, 4, 1, "R4");
    lookup(21, 8, 1, "R4");
    lookup(21, 8, 0, "R4");
    lookup(21, 8, 0, "R5");
    // R5 and R6: status bits
    lookup(12, 2, 0, "R5");
    lookup(12, 2, 0, "R5");
    lookup(13, 2, 1, "R6");
    lookup(13, 2, 0, "R6");
    // R11: lookup alongside refill of same page
    lookupValid = 1; lookupVa = {30'd40, 13'd9};
    refillValid = 1; refillVpn = 30'd40; refillPfn = 21'd777;
    refillRdPerm = 2'd1; refillWrPerm = 2'd1;
    step("R11"); clearIn();
    lookup(40, 9, 0, "R11");
    // R10: flush, and flush beating refill
    pteWrite = 1; step("R10"); clearIn();
    lookup(10, 0, 0, "R10");
    lookup(40, 0, 0, "R10");
    refill(50, 5, 1, 1, "R10");
    pteWrite = 1; refillValid = 1; refillVpn = 30'd51; refillPfn = 21'd6;
    step("R10"); clearIn();
    lookup(50, 0, 0, "R10");
    lookup(51, 0, 0, "R10");
    // R8: full buffer, random victims
    for (int i = 0; i < 32; i++) refill(200 + i, 1000 + i, 1, 1, "R8");
    for (int n = 0; n < 6; n++) begin
      refill(400 + n, 2000 + n, 1, 1, "R8");
      step("R8");
    end
    for (int i = 0; i < 32; i++) lookup(mVpn[i], i, 0, "R8");
    // R9: victim equals most recent entry, middle and wrap
    collideRefill(7, 500, "R9");
    collideRefill(31, 501, "R9");
    lookup(200, 0, 0, "R8");
    summary();
  end
endmodule